// File: doc/BRIEF.md
# Masked Vector Gather Engine

The engine fills an eight-lane destination vector of 64-bit elements from memory. Each lane's address is formed from a shared 64-bit base plus that lane's signed 32-bit index, scaled by 1, 2, 4 or 8. An 8-bit completion mask selects the lanes still to be loaded. The engine treats each element as opaque 64-bit data. Memory is read a whole 64-byte line at a time over a valid/ready request channel and a 512-bit response channel.

A pass picks the line that holds the lowest-numbered active lane and fetches that line once. It then loads every active lane whose address falls in the same line and clears those mask bits. In single mode one pass is made, and the shrunken mask comes back so that software can issue the operation again. In repeat mode the engine keeps making passes until the mask is empty, with one fetch for each distinct line touched.

Before any memory access, the engine rejects two cases with a fault: a destination register number equal to the index register number, and an active lane whose address is not 8-byte aligned. An empty input mask completes at once.

Top module: `vgather_engine`

## Requirements
- R1: The address of lane i is base + sign_extend(index[i]) * 2^scaleSel, taken modulo 2^64. scaleSel codes 0, 1, 2 and 3 mean 1, 2, 4 and 8. Lane i's index sits at bits 32*i+31:32*i of indexVec. A request carries the line address, which is the lane address with its 6 low bits cleared.
- R2: Each pass requests the line of the active lane with the lowest lane number, that is, the lowest set bit of the current mask.
- R3: When a response is accepted, every active lane whose address has the requested line address receives 64-bit word w = address[5:3] of the line, found at memRspData[64*w+63:64*w]. That lane's mask bit is cleared. Any other lane keeps its destination value (lane i at bits 64*i+63:64*i) and its mask bit.
- R4: In single mode (repeatMode=0) exactly one pass is made. done then pulses for one cycle, and maskOut holds the remaining mask.
- R5: In repeat mode the engine keeps making passes until the mask is zero, and issues exactly one request for each pass.
- R6: If dstReg equals idxReg, the cycle after start shows done=1 and fault=1. No request is issued, and maskOut and dstOut equal maskIn and dstIn.
- R7: An active lane with address[2:0] != 0 causes the same immediate fault as R6. A misaligned lane whose mask bit is 0 is ignored.
- R8: A zero maskIn gives done=1 with fault=0 in the cycle after start, and no request.
- R9: memReqValid stays high, with memReqAddr stable, until memReqReady is seen. The engine issues no request and no response-ready while it is not busy.
- R10: A start while busy is ignored and does not change the result of the running operation.
- R11: After reset the engine is idle: busy, done, fault, memReqValid and maskOut are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| repeatMode | input | 1 | 1: loop until mask empty; 0: single pass |
| dstReg | input | 5 | Destination register number |
| idxReg | input | 5 | Index register number |
| baseAddr | input | 64 | Base byte address |
| indexVec | input | 256 | Eight signed 32-bit indices |
| scaleSel | input | 2 | Scale code (factor 2^scaleSel) |
| maskIn | input | 8 | Completion mask, one bit per lane |
| dstIn | input | 512 | Old destination vector contents |
| memReqValid | output | 1 | Line request valid |
| memReqReady | input | 1 | Memory accepts the request |
| memReqAddr | output | 64 | 64-byte-aligned line address |
| memRspValid | input | 1 | Line data valid |
| memRspReady | output | 1 | Engine accepts line data |
| memRspData | input | 512 | Returned 64-byte line |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Last operation faulted (held until next start) |
| maskOut | output | 8 | Updated mask |
| dstOut | output | 512 | Updated destination vector |

## Verification
Four kinds of lane placement are tried. In the first, all lanes fall in one line, so one fetch must complete everything. In the second, every lane has its own line, which shows whether the lowest active lane is chosen. In the third, negative and mixed indices share some lines, which tests lane matching and the word offset. The fourth places addresses across the top of the 64-bit space to test wrap. Single mode is also driven in a software-style loop that feeds the returned mask back in, and the final vector must match the one from repeat mode. Alias faults, misaligned active and inactive lanes, an empty mask and a start issued mid-operation each test the early-exit paths. Request and response delays are varied to test the hold rule.

// File: rtl/vgather_pkg.sv
package vgather_pkg;

  typedef struct packed {
    logic load;   // capture operands from the ports
    logic apply;  // merge accepted line into lanes and mask
  } vgStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_RSP  = 2'd2
  } vgState_t;

endpackage

// File: rtl/vgather_lane_addr.sv
module vgather_lane_addr #(
  parameter int ADDR_W = 64,
  parameter int IDX_W  = 32
) (
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [IDX_W-1:0]  index,
  input  logic [1:0]        scaleSel,
  output logic [ADDR_W-1:0] laneAddr
);
  logic [ADDR_W-1:0] idxExt;
  logic [ADDR_W-1:0] idxScaled;

  always_comb begin
    idxExt    = {{(ADDR_W-IDX_W){index[IDX_W-1]}}, index};
    idxScaled = idxExt << scaleSel;
    laneAddr  = baseAddr + idxScaled;
  end
endmodule

// File: rtl/vgather_datapath.sv
module vgather_datapath
  import vgather_pkg::*;
#(
  parameter int LANES      = 8,
  parameter int ELEM_W     = 64,
  parameter int ADDR_W     = 64,
  parameter int IDX_W      = 32,
  parameter int LINE_BYTES = 64,
  parameter int REG_W      = 5
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  vgStrobe_t                 strb,
  input  logic [REG_W-1:0]          dstReg,
  input  logic [REG_W-1:0]          idxReg,
  input  logic [ADDR_W-1:0]         baseIn,
  input  logic [LANES*IDX_W-1:0]    indexIn,
  input  logic [1:0]                scaleIn,
  input  logic [LANES-1:0]          maskIn,
  input  logic [LANES*ELEM_W-1:0]   dstIn,
  input  logic [LINE_BYTES*8-1:0]   rspData,
  output logic                      aliasHit,
  output logic                      alignFault,
  output logic                      maskInZero,
  output logic                      remZero,
  output logic [ADDR_W-1:0]         lineAddr,
  output logic [LANES-1:0]          maskQ,
  output logic [LANES*ELEM_W-1:0]   dstQ
);
  localparam int OFF_W   = $clog2(LINE_BYTES);
  localparam int WORDS   = (LINE_BYTES*8)/ELEM_W;
  localparam int ALIGN_W = $clog2(ELEM_W/8);
  localparam int LANE_W  = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int TAG_W   = ADDR_W - OFF_W;

  logic [ADDR_W-1:0]      baseQ;
  logic [LANES*IDX_W-1:0] indexQ;
  logic [1:0]             scaleQ;

  logic [ADDR_W-1:0]      laneAddr [LANES];
  logic [ELEM_W-1:0]      lineWord [WORDS];
  logic [LANES-1:0]       laneHit;
  logic [LANES-1:0]       laneMisaligned;
  logic [LANES-1:0]       maskNext;
  logic [LANE_W-1:0]      lowIdx;
  logic [TAG_W-1:0]       lineTag;

  // Split the returned line into element-sized words
  genvar w;
  generate
    for (w = 0; w < WORDS; w++) begin : g_words
      assign lineWord[w] = rspData[w*ELEM_W +: ELEM_W];
    end
  endgenerate

  // Per-lane address, line match and early alignment check
  genvar i;
  generate
    for (i = 0; i < LANES; i++) begin : g_lane
      logic [ALIGN_W-1:0] lowSum;
      logic [ALIGN_W-1:0] idxLow;
      logic [$clog2(WORDS)-1:0] wordSel;

      vgather_lane_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_addr (
        .baseAddr (baseQ),
        .index    (indexQ[i*IDX_W +: IDX_W]),
        .scaleSel (scaleQ),
        .laneAddr (laneAddr[i])
      );

      // alignment only depends on the low bits, so evaluate it on the raw operands
      always_comb begin
        idxLow = indexIn[i*IDX_W +: ALIGN_W] << scaleIn;
        lowSum = baseIn[ALIGN_W-1:0] + idxLow;
        laneMisaligned[i] = maskIn[i] && (lowSum != '0);
      end

      assign laneHit[i] = maskQ[i] && (laneAddr[i][ADDR_W-1:OFF_W] == lineTag);
      assign wordSel    = laneAddr[i][OFF_W-1:ALIGN_W];

      always_ff @(posedge clk) begin
        if (!rstN) begin
          dstQ[i*ELEM_W +: ELEM_W] <= '0;
        end else if (strb.load) begin
          dstQ[i*ELEM_W +: ELEM_W] <= dstIn[i*ELEM_W +: ELEM_W];
        end else if (strb.apply && laneHit[i]) begin
          dstQ[i*ELEM_W +: ELEM_W] <= lineWord[wordSel];
        end
      end

      AST_LANE_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
        strb.apply && maskQ[i] |-> laneAddr[i][ALIGN_W-1:0] == '0)
        else $error("active lane %0d misaligned during fetch", i); // R7
    end
  endgenerate

  // Lowest set mask bit picks the line
  always_comb begin
    lowIdx = '0;
    for (int k = LANES-1; k >= 0; k--) begin
      if (maskQ[k]) lowIdx = LANE_W'(k);
    end
  end

  assign lineTag    = laneAddr[lowIdx][ADDR_W-1:OFF_W];
  assign lineAddr   = {lineTag, {OFF_W{1'b0}}};
  assign maskNext   = maskQ & ~laneHit;
  assign remZero    = (maskNext == '0);
  assign aliasHit   = (dstReg == idxReg);
  assign alignFault = |laneMisaligned;
  assign maskInZero = (maskIn == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ  <= '0;
      indexQ <= '0;
      scaleQ <= '0;
      maskQ  <= '0;
    end else if (strb.load) begin
      baseQ  <= baseIn;
      indexQ <= indexIn;
      scaleQ <= scaleIn;
      maskQ  <= maskIn;
    end else if (strb.apply) begin
      maskQ  <= maskNext;
    end
  end

  AST_MASK_SUBSET: assert property (@(posedge clk) disable iff (!rstN)
    strb.apply |=> (maskQ & ~$past(maskQ)) == '0)
    else $error("mask gained bits on a pass"); // R3

  AST_MASK_SHRINKS: assert property (@(posedge clk) disable iff (!rstN)
    strb.apply |=> maskQ != $past(maskQ))
    else $error("pass made no progress"); // R2

  AST_LOWEST_SERVED: assert property (@(posedge clk) disable iff (!rstN)
    strb.apply |=> maskQ[$past(lowIdx)] == 1'b0)
    else $error("lowest active lane not cleared"); // R2

endmodule

// File: rtl/vgather_ctrl.sv
module vgather_ctrl
  import vgather_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      repeatMode,
  input  logic      aliasHit,
  input  logic      alignFault,
  input  logic      maskInZero,
  input  logic      remZero,
  input  logic      memReqReady,
  input  logic      memRspValid,
  output vgStrobe_t strb,
  output logic      memReqValid,
  output logic      memRspReady,
  output logic      busy,
  output logic      done,
  output logic      fault
);
  vgState_t state;
  logic     repQ;
  logic     doneQ;
  logic     faultQ;
  logic     earlyFault;

  assign earlyFault  = aliasHit || alignFault;
  assign strb.load   = (state == ST_IDLE) && start;
  assign strb.apply  = (state == ST_RSP) && memRspValid;
  assign memReqValid = (state == ST_REQ);
  assign memRspReady = (state == ST_RSP);
  assign busy        = (state != ST_IDLE);
  assign done        = doneQ;
  assign fault       = faultQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      repQ   <= 1'b0;
      doneQ  <= 1'b0;
      faultQ <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            repQ   <= repeatMode;
            faultQ <= earlyFault;
            if (earlyFault || maskInZero) doneQ <= 1'b1;
            else                          state <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (memReqReady) state <= ST_RSP;
        end
        ST_RSP: begin
          if (memRspValid) begin
            if (repQ && !remZero) begin
              state <= ST_REQ;
            end else begin
              state <= ST_IDLE;
              doneQ <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid)
    else $error("request dropped before ready"); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReqValid && !memRspReady)
    else $error("memory activity while idle"); // R9

  AST_FAULT_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> !memReqValid)
    else $error("request issued with fault"); // R6

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy)
    else $error("done while still busy"); // R4

endmodule

// File: rtl/vgather_engine.sv
module vgather_engine
  import vgather_pkg::*;
#(
  parameter int LANES      = 8,
  parameter int ELEM_W     = 64,
  parameter int ADDR_W     = 64,
  parameter int IDX_W      = 32,
  parameter int LINE_BYTES = 64,
  parameter int REG_W      = 5
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic                    repeatMode,
  input  logic [REG_W-1:0]        dstReg,
  input  logic [REG_W-1:0]        idxReg,
  input  logic [ADDR_W-1:0]       baseAddr,
  input  logic [LANES*IDX_W-1:0]  indexVec,
  input  logic [1:0]              scaleSel,
  input  logic [LANES-1:0]        maskIn,
  input  logic [LANES*ELEM_W-1:0] dstIn,
  output logic                    memReqValid,
  input  logic                    memReqReady,
  output logic [ADDR_W-1:0]       memReqAddr,
  input  logic                    memRspValid,
  output logic                    memRspReady,
  input  logic [LINE_BYTES*8-1:0] memRspData,
  output logic                    busy,
  output logic                    done,
  output logic                    fault,
  output logic [LANES-1:0]        maskOut,
  output logic [LANES*ELEM_W-1:0] dstOut
);
  vgStrobe_t strb;
  logic      aliasHit;
  logic      alignFault;
  logic      maskInZero;
  logic      remZero;

  vgather_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .repeatMode  (repeatMode),
    .aliasHit    (aliasHit),
    .alignFault  (alignFault),
    .maskInZero  (maskInZero),
    .remZero     (remZero),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .strb        (strb),
    .memReqValid (memReqValid),
    .memRspReady (memRspReady),
    .busy        (busy),
    .done        (done),
    .fault       (fault)
  );

  vgather_datapath #(
    .LANES(LANES), .ELEM_W(ELEM_W), .ADDR_W(ADDR_W),
    .IDX_W(IDX_W), .LINE_BYTES(LINE_BYTES), .REG_W(REG_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .dstReg     (dstReg),
    .idxReg     (idxReg),
    .baseIn     (baseAddr),
    .indexIn    (indexVec),
    .scaleIn    (scaleSel),
    .maskIn     (maskIn),
    .dstIn      (dstIn),
    .rspData    (memRspData),
    .aliasHit   (aliasHit),
    .alignFault (alignFault),
    .maskInZero (maskInZero),
    .remZero    (remZero),
    .lineAddr   (memReqAddr),
    .maskQ      (maskOut),
    .dstQ       (dstOut)
  );

  AST_REQ_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> $stable(memReqAddr))
    else $error("request address moved while waiting"); // R9

  AST_REQ_LINE_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> memReqAddr[$clog2(LINE_BYTES)-1:0] == '0)
    else $error("request not line aligned"); // R1

endmodule

// File: tb/vgather_engine_tb.sv
module vgather_engine_tb;
  logic         clk = 1'b0;
  logic         rstN;
  logic         start, repeatMode;
  logic [4:0]   dstReg, idxReg;
  logic [63:0]  baseAddr;
  logic [255:0] indexVec;
  logic [1:0]   scaleSel;
  logic [7:0]   maskIn;
  logic [511:0] dstIn;
  logic         memReqValid, memReqReady, memRspValid, memRspReady;
  logic [63:0]  memReqAddr;
  logic [511:0] memRspData;
  logic         busy, done, fault;
  logic [7:0]   maskOut;
  logic [511:0] dstOut;

  int vectors = 0;
  int miscompares = 0;

  logic [31:0]  idxA [8];
  logic [63:0]  expLines[$];
  logic [7:0]   expMask;
  logic [511:0] expDst;
  bit           expFault;
  bit           noReq;
  int           reqDelay = 1;
  int           rspDelay = 1;
  int           reqSeen;

  always #10ns clk = ~clk;  // 50 MHz

  vgather_engine u_dut (
    .clk(clk), .rstN(rstN), .start(start), .repeatMode(repeatMode),
    .dstReg(dstReg), .idxReg(idxReg), .baseAddr(baseAddr), .indexVec(indexVec),
    .scaleSel(scaleSel), .maskIn(maskIn), .dstIn(dstIn),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspReady(memRspReady), .memRspData(memRspData),
    .busy(busy), .done(done), .fault(fault), .maskOut(maskOut), .dstOut(dstOut)
  );

  task automatic check(string req, string what, logic [511:0] act, logic [511:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  function automatic logic [63:0] memWord(logic [63:0] line, int w);
    return line ^ (64'h9E37_79B9_7F4A_7C15 * 64'(w + 1));
  endfunction

  function automatic logic [511:0] lineData(logic [63:0] line);
    logic [511:0] d;
    for (int w = 0; w < 8; w++) d[w*64 +: 64] = memWord(line, w);
    return d;
  endfunction

  function automatic logic [63:0] laneAddrOf(logic [63:0] b, logic [1:0] sc, int i);
    return b + (64'($signed(idxA[i])) << sc);
  endfunction

  // Behavioural model of one whole operation: fills expLines, expMask, expDst, expFault
  task automatic model(logic [63:0] b, logic [1:0] sc, logic [7:0] m, bit rep,
                       logic [4:0] dr, logic [4:0] ir, logic [511:0] d0);
    logic [7:0]  mk;
    logic [63:0] a, ln;
    int low;
    expLines.delete();
    expFault = (dr == ir);
    for (int i = 0; i < 8; i++)
      if (m[i] && laneAddrOf(b, sc, i)[2:0] != 3'd0) expFault = 1'b1;
    mk = m;
    expDst = d0;
    if (!expFault) begin
      while (mk != 8'd0) begin
        low = 0;
        while (!mk[low]) low++;
        ln = laneAddrOf(b, sc, low) & ~64'h3F;
        expLines.push_back(ln);
        for (int i = 0; i < 8; i++) begin
          a = laneAddrOf(b, sc, i);
          if (mk[i] && (a & ~64'h3F) == ln) begin
            expDst[i*64 +: 64] = memWord(ln, int'(a[5:3]));
            mk[i] = 1'b0;
          end
        end
        if (!rep) break;
      end
    end
    expMask = mk;
  endtask

  // Memory responder plus per-clock request comparison
  initial begin
    int phase = 0;
    int cnt = 0;
    logic [63:0] curLine = '0;
    logic [63:0] firstAddr = '0;
    memReqReady = 1'b0;
    memRspValid = 1'b0;
    memRspData  = '0;
    forever begin
      @(negedge clk);
      if (noReq && memReqValid) check("R6", "request during early exit", 1, 0);
      case (phase)
        0: begin
          if (memReqValid) begin
            cnt++;
            if (cnt == 1) firstAddr = memReqAddr;
            if (cnt >= reqDelay) begin
              check("R9", "request address held", memReqAddr, firstAddr);
              if (expLines.size() == 0) begin
                check("R5", "unexpected request", memReqAddr, 0);
              end else begin
                check("R2", "requested line", memReqAddr, expLines.pop_front());
              end
              reqSeen++;
              memReqReady = 1'b1;
              curLine = memReqAddr;
              phase = 1;
              cnt = 0;
            end
          end else cnt = 0;
        end
        1: begin memReqReady = 1'b0; phase = 2; end
        2: begin
          cnt++;
          if (cnt >= rspDelay) begin
            memRspValid = 1'b1;
            memRspData = lineData(curLine);
            phase = 3;
            cnt = 0;
          end
        end
        default: begin memRspValid = 1'b0; phase = 0; end
      endcase
    end
  end

  task automatic setIdx();
    for (int i = 0; i < 8; i++) indexVec[i*32 +: 32] = idxA[i];
  endtask

  task automatic runOp(string req, logic [63:0] b, logic [1:0] sc, logic [7:0] m, bit rep,
                       logic [4:0] dr, logic [4:0] ir, logic [511:0] d0, bit poke);
    int n;
    int expReqs;
    bit immediate;
    setIdx();
    model(b, sc, m, rep, dr, ir, d0);
    expReqs = expLines.size();
    immediate = expFault || (m == 8'd0);
    baseAddr = b; scaleSel = sc; maskIn = m; repeatMode = rep;
    dstReg = dr; idxReg = ir; dstIn = d0;
    noReq = immediate;
    reqSeen = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (immediate) begin
      check(req, "done next cycle", done, 1);
      check(req, "busy after early exit", busy, 0);
    end else begin
      n = 0;
      while (!done && n < 2000) begin
        if (poke && n == 2) begin
          start = 1'b1; maskIn = 8'h01; dstReg = 5'd3; idxReg = 5'd3;
        end else start = 1'b0;
        @(negedge clk);
        n++;
      end
      start = 1'b0;
      check(req, "done seen", done, 1);
    end
    check(req, "fault", fault, expFault);
    check(req, "maskOut", maskOut, expMask);
    check(req, "dstOut", dstOut, expDst);
    check(req, "request count", reqSeen, expReqs);
    @(negedge clk);
    noReq = 1'b0;
  endtask

  initial begin
    #3ms;
    miscompares++;
    $display("FAIL watchdog: actual hung expected finish");
    finishRun();
  end

  initial begin
    logic [511:0] d0;
    logic [7:0] m;
    rstN = 1'b0; start = 1'b0; repeatMode = 1'b0; dstReg = 5'd1; idxReg = 5'd2;
    baseAddr = '0; indexVec = '0; scaleSel = '0; maskIn = '0; dstIn = '0;
    noReq = 1'b0;
    for (int i = 0; i < 8; i++) d0[i*64 +: 64] = 64'hDEAD_0000_0000_0000 | 64'(i);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11", "busy", busy, 0);
    check("R11", "done", done, 0);
    check("R11", "fault", fault, 0);
    check("R11", "memReqValid", memReqValid, 0);
    check("R11", "maskOut", maskOut, 0);

    // R1 R3 R4: all lanes inside one line, scale 8
    for (int i = 0; i < 8; i++) idxA[i] = 32'(i);
    runOp("R3", 64'h1000, 2'd3, 8'hFF, 1'b0, 5'd1, 5'd2, d0, 1'b0);

    // R2 R4: each lane its own line, single pass services lane 2 only
    for (int i = 0; i < 8; i++) idxA[i] = 32'(i * 16);
    reqDelay = 3; rspDelay = 2;
    runOp("R4", 64'h2000, 2'd2, 8'b1011_0100, 1'b0, 5'd1, 5'd2, d0, 1'b0);

    // R5 R1: negative and shared indices, scale 1, repeat
    idxA = '{32'd0, -32'sd8, 32'd64, 32'd72, -32'sd64, 32'd8, 32'd200, 32'd128};
    reqDelay = 1; rspDelay = 3;
    runOp("R5", 64'h8000, 2'd0, 8'hFF, 1'b1, 5'd1, 5'd2, d0, 1'b0);

    // R1 wrap across the top of the address space, scale 4
    idxA = '{32'd0, 32'd16, 32'd2, 32'd18, 32'd4, 32'd20, 32'd6, 32'd22};
    reqDelay = 2; rspDelay = 1;
    runOp("R1", 64'hFFFF_FFFF_FFFF_FFC0, 2'd2, 8'hFF, 1'b1, 5'd1, 5'd2, d0, 1'b0);

    // R1 scale 2 with repeat
    idxA = '{32'd4, 32'd100, -32'sd4, 32'd36, 32'd0, 32'd68, 32'd132, 32'd8};
    runOp("R1", 64'h4000, 2'd1, 8'h7E, 1'b1, 5'd1, 5'd2, d0, 1'b0);

    // R6 alias fault
    runOp("R6", 64'h4000, 2'd1, 8'h5A, 1'b1, 5'd7, 5'd7, d0, 1'b0);

    // R7 misaligned active lane
    idxA = '{32'd0, 32'd8, 32'd16, 32'd1, 32'd32, 32'd40, 32'd48, 32'd56};
    runOp("R7", 64'h100, 2'd0, 8'h0F, 1'b1, 5'd1, 5'd2, d0, 1'b0);
    // R7 misaligned lane inactive: ignored
    runOp("R7", 64'h100, 2'd0, 8'hF7, 1'b1, 5'd1, 5'd2, d0, 1'b0);

    // R8 empty mask
    runOp("R8", 64'h100, 2'd0, 8'h00, 1'b1, 5'd1, 5'd2, d0, 1'b0);

    // R10 start while busy is ignored
    for (int i = 0; i < 8; i++) idxA[i] = 32'(i * 16);
    reqDelay = 2; rspDelay = 2;
    runOp("R10", 64'h3000, 2'd2, 8'hC3, 1'b1, 5'd1, 5'd2, d0, 1'b1);

    // R4: software loop of single passes reaches the repeat-mode result
    idxA = '{32'd0, -32'sd8, 32'd64, 32'd72, -32'sd64, 32'd8, 32'd200, 32'd128};
    reqDelay = 1; rspDelay = 1;
    m = 8'hFF;
    for (int pass = 0; pass < 8 && m != 8'd0; pass++) begin
      runOp("R4", 64'h8000, 2'd0, m, 1'b0, 5'd1, 5'd2, d0, 1'b0);
      m = maskOut;
      d0 = dstOut;
    end
    check("R4", "loop mask empty", maskOut, 0);
    model(64'h8000, 2'd0, 8'hFF, 1'b1, 5'd1, 5'd2,
          {8{64'hDEAD_0000_0000_0000}} | {64'd7, 64'd6, 64'd5, 64'd4, 64'd3, 64'd2, 64'd1, 64'd0});
    check("R4", "loop equals repeat result", dstOut, expDst);

    finishRun();
  end
endmodule